// File: doc/BRIEF.md
# ECC Error Status and Interrupt Register Bank

This block is the software-visible control and status block that sits next to a memory controller's error-correction encoder and decoder. For every read, the decoder reports two one-cycle pulses: one for a correctable error and one for an uncorrectable error. The block latches each pulse into a sticky status bit and counts correctable errors in a counter that saturates instead of wrapping. It drives a single level-sensitive interrupt. Each of the two error sources has its own enable into that interrupt.

A control bit turns read-side checking on or off. It is fed back to the read path. While checking is off, no error is recorded and the counter does not move. The write-side code generation enable stays asserted in either case. Software reaches the registers through a plain single-cycle port: a write is taken on the clock edge when the write strobe is high, and read data is a combinational function of the address.

Top module: `ecc_irq_regs`

## Requirements
- R1: After reset, both status bits are 0, both interrupt enables are 0, the counter is 0, and the checking control bit equals parameter `CHECK_RESET` (default 1).
- R2: `irq` is high exactly when (correctable status AND correctable enable) OR (uncorrectable status AND uncorrectable enable).
- R3: The interrupt enable register is at offset 0x4. The correctable enable is bit 1, the uncorrectable enable is bit 0, and bits 31:2 read as 0.
- R4: The status register is at offset 0x0. The correctable status is bit 1 and the uncorrectable status is bit 0, and bits 31:2 read as 0. With checking on, an event pulse sets its bit, and the bit stays set until software clears it.
- R5: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R6: The checking control bit is bit 0 at offset 0x8 and is driven on `checkEn`. While it is 0, event pulses change neither the status bits nor the counter.
- R7: `genEn` is 1 at all times, whatever the checking control bit holds.
- R8: The counter at offset 0xC, bits 7:0 (bits 31:8 read 0), adds one for each correctable event taken while checking is on. It holds at 255 instead of wrapping to 0.
- R9: A software write to offset 0xC loads bits 7:0 of the write data into the counter, whatever value it held before.
- R10: In a cycle where a software write and a hardware event hit the same status bit or the counter, the software write wins. A write-1 clear beats a set, and a counter write beats an increment.
- R11: A read at any offset other than 0x0, 0x4, 0x8 and 0xC returns 0. A write at any such offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register access |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data for `addr` |
| ceEvt | input | 1 | Correctable error pulse from the decoder |
| ueEvt | input | 1 | Uncorrectable error pulse from the decoder |
| irq | output | 1 | Level interrupt |
| checkEn | output | 1 | Read-side checking enable to the read path |
| genEn | output | 1 | Write-side code generation enable |

## Verification
The bench sweeps all 16 combinations of the two enables and the two status bits. A design with swapped enable bits, or with an ungated interrupt, would then raise `irq` where it must stay low. The bench drives the counter through 255 with continuous correctable pulses. A counter that wraps would read 0 or a small value there, and one that stops early would read below 255. Events are sent in the same cycle as status clears and counter writes, which catches a design that lets hardware win. Events are also sent while checking is off, which catches a design that still latches status or counts. A sweep of every offset in the address space catches decode aliasing, where an unmapped offset returns or overwrites a real register.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;

  // Word index of each register (byte offset >> 2).
  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_IRQEN  = 1;
  localparam int unsigned IDX_CHECK  = 2;
  localparam int unsigned IDX_COUNT  = 3;

  // Bit position of each error source in the status and enable registers.
  localparam int unsigned BIT_UE = 0;
  localparam int unsigned BIT_CE = 1;

  typedef struct packed {
    logic wrStatus;
    logic wrIrqEn;
    logic wrCheck;
    logic wrCount;
  } regStrobes_t;

endpackage

// File: rtl/ecc_regs_ctrl.sv
module ecc_regs_ctrl
  import ecc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        statusQ,
  input  logic [1:0]        irqEnQ,
  input  logic              checkQ,
  input  logic [CNT_W-1:0]  countQ,
  output regStrobes_t       strobes,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] wordIdx;

  assign aligned = (addr[1:0] == 2'b00);
  assign wordIdx = addr[ADDR_W-1:2];

  always_comb begin
    strobes          = '0;
    strobes.wrStatus = wrEn && aligned && (wordIdx == IDX_W'(IDX_STATUS));
    strobes.wrIrqEn  = wrEn && aligned && (wordIdx == IDX_W'(IDX_IRQEN));
    strobes.wrCheck  = wrEn && aligned && (wordIdx == IDX_W'(IDX_CHECK));
    strobes.wrCount  = wrEn && aligned && (wordIdx == IDX_W'(IDX_COUNT));
  end

  always_comb begin
    rdData = '0;
    if (aligned) begin
      if (wordIdx == IDX_W'(IDX_STATUS)) rdData = DATA_W'(statusQ);
      else if (wordIdx == IDX_W'(IDX_IRQEN)) rdData = DATA_W'(irqEnQ);
      else if (wordIdx == IDX_W'(IDX_CHECK)) rdData = DATA_W'(checkQ);
      else if (wordIdx == IDX_W'(IDX_COUNT)) rdData = DATA_W'(countQ);
    end
  end

  // At most one register is selected per access (R11 decode).
  always_comb begin
    a_onehot_strobe_r11: assert ($onehot0(strobes));
  end

endmodule

// File: rtl/ecc_regs_dp.sv
module ecc_regs_dp
  import ecc_regs_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 8,
  parameter bit          CHECK_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ceEvt,
  input  logic              ueEvt,
  output logic [1:0]        statusQ,
  output logic [1:0]        irqEnQ,
  output logic              checkQ,
  output logic [CNT_W-1:0]  countQ,
  output logic              irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0] evtVec;
  logic       unusedWrBits;

  assign evtVec = {ceEvt, ueEvt};
  assign unusedWrBits = ^wrData[DATA_W-1:CNT_W];

  // Sticky status bits: hardware sets, write-1 clears, clear wins.
  for (genvar i = 0; i < 2; i++) begin : g_sts
    logic clrBit;
    assign clrBit = strobes.wrStatus && wrData[i];

    always_ff @(posedge clk) begin
      if (!rstN)               statusQ[i] <= 1'b0;
      else if (clrBit)         statusQ[i] <= 1'b0;
      else if (evtVec[i] && checkQ) statusQ[i] <= 1'b1;
    end

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[i] && !clrBit) |=> statusQ[i]);
    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
      clrBit |=> !statusQ[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnQ <= 2'b00;
      checkQ <= CHECK_RESET;
    end else begin
      if (strobes.wrIrqEn) irqEnQ <= wrData[1:0];
      if (strobes.wrCheck) checkQ <= wrData[0];
    end
  end

  // Saturating correctable-error counter; software load has priority.
  always_ff @(posedge clk) begin
    if (!rstN)                                     countQ <= '0;
    else if (strobes.wrCount)                      countQ <= wrData[CNT_W-1:0];
    else if (ceEvt && checkQ && countQ != CNT_MAX) countQ <= countQ + 1'b1;
  end

  assign irq = (statusQ[BIT_CE] && irqEnQ[BIT_CE]) ||
               (statusQ[BIT_UE] && irqEnQ[BIT_UE]);

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == CNT_MAX && !strobes.wrCount) |=> countQ == CNT_MAX);
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ceEvt && checkQ && !strobes.wrCount && countQ != CNT_MAX)
      |=> countQ == $past(countQ) + 1'b1);
  p_off_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!checkQ && !strobes.wrStatus && !strobes.wrCount)
      |=> ($stable(statusQ) && $stable(countQ)));
  p_irq_needs_status_r2: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusQ != 2'b00 && irqEnQ != 2'b00));
  p_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrCount |=> countQ == $past(wrData[CNT_W-1:0]));

endmodule

// File: rtl/ecc_irq_regs.sv
module ecc_irq_regs
  import ecc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 8,
  parameter bit          CHECK_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              ceEvt,
  input  logic              ueEvt,
  output logic              irq,
  output logic              checkEn,
  output logic              genEn
);

  regStrobes_t      strobes;
  logic [1:0]       statusQ;
  logic [1:0]       irqEnQ;
  logic             checkQ;
  logic [CNT_W-1:0] countQ;

  ecc_regs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .statusQ (statusQ),
    .irqEnQ  (irqEnQ),
    .checkQ  (checkQ),
    .countQ  (countQ),
    .strobes (strobes),
    .rdData  (rdData)
  );

  ecc_regs_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CHECK_RESET(CHECK_RESET)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .ceEvt   (ceEvt),
    .ueEvt   (ueEvt),
    .statusQ (statusQ),
    .irqEnQ  (irqEnQ),
    .checkQ  (checkQ),
    .countQ  (countQ),
    .irq     (irq)
  );

  assign checkEn = checkQ;
  assign genEn   = 1'b1;

endmodule

// File: tb/test_ecc_irq_regs.sv
module test_ecc_irq_regs;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              ceEvt = 1'b0;
  logic              ueEvt = 1'b0;
  logic              irq, checkEn, genEn;

  int checks = 0;
  int failures = 0;

  // Bench model of the registers.
  logic       mCe, mUe, mCeEn, mUeEn, mOn;
  logic [7:0] mCnt;

  always #10 clk = ~clk;

  ecc_irq_regs i_ecc_irq_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ceEvt(ceEvt), .ueEvt(ueEvt), .irq(irq),
    .checkEn(checkEn), .genEn(genEn)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One clock cycle with the given stimulus; model updated from the requirements.
  task automatic cyc(input logic we, input logic [4:0] a, input logic [31:0] d,
                     input logic ce, input logic ue);
    logic nCe, nUe;
    wrEn = we; addr = a; wrData = d; ceEvt = ce; ueEvt = ue;
    @(posedge clk); #1;
    nCe = mCe | (ce & mOn);
    nUe = mUe | (ue & mOn);
    if (we && a == 5'h00) begin
      if (d[1]) nCe = 1'b0;
      if (d[0]) nUe = 1'b0;
    end
    if (we && a == 5'h0C) mCnt = d[7:0];
    else if (ce && mOn && mCnt != 8'hFF) mCnt = mCnt + 8'd1;
    if (we && a == 5'h04) begin mCeEn = d[1]; mUeEn = d[0]; end
    if (we && a == 5'h08) mOn = d[0];
    mCe = nCe; mUe = nUe;
    wrEn = 1'b0; ceEvt = 1'b0; ueEvt = 1'b0; wrData = '0;
  endtask

  function automatic logic [31:0] expRead(input logic [4:0] a);
    case (a)
      5'h00: return {30'd0, mCe, mUe};
      5'h04: return {30'd0, mCeEn, mUeEn};
      5'h08: return {31'd0, mOn};
      5'h0C: return {24'd0, mCnt};
      default: return 32'd0;
    endcase
  endfunction

  task automatic rd(input string req, input logic [4:0] a);
    addr = a; #1;
    chk(req, $sformatf("read @%0h", a), rdData, expRead(a));
  endtask

  task automatic checkAll(input string req);
    rd(req, 5'h00); rd(req, 5'h04); rd(req, 5'h08); rd(req, 5'h0C);
    chk("R2", {req, " irq"}, {31'd0, irq}, {31'd0, (mCe & mCeEn) | (mUe & mUeEn)});
    chk("R6", {req, " checkEn"}, {31'd0, checkEn}, {31'd0, mOn});
    chk("R7", {req, " genEn"}, {31'd0, genEn}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mCe = 0; mUe = 0; mCeEn = 0; mUeEn = 0; mOn = 1; mCnt = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    checkAll("R1");

    // R11: every offset, reads then writes at unmapped offsets.
    for (int a = 0; a < 32; a++) rd("R11", 5'(a));
    for (int a = 0; a < 32; a++)
      if (a != 0 && a != 4 && a != 8 && a != 12) cyc(1, 5'(a), 32'hFFFF_FFFF, 0, 0);
    checkAll("R11");

    // R2/R3/R4: all enable and status combinations.
    for (int en = 0; en < 4; en++) begin
      for (int st = 0; st < 4; st++) begin
        cyc(1, 5'h00, 32'h3, 0, 0);
        cyc(1, 5'h04, 32'hFFFF_FFFC | 32'(en), st[1], st[0]);
        cyc(0, 5'h00, 0, 0, 0);
        checkAll("R3");
        chk("R4", "status", {30'd0, mCe, mUe}, {30'd0, 2'(st)});
      end
    end

    // R5: single-bit write-1 clear, write-0 keeps.
    cyc(0, 5'h00, 0, 1, 1);
    cyc(1, 5'h00, 32'h0, 0, 0);
    checkAll("R5");
    cyc(1, 5'h00, 32'h2, 0, 0);
    checkAll("R5");
    cyc(1, 5'h00, 32'h1, 0, 0);
    checkAll("R5");

    // R8: run past saturation.
    cyc(1, 5'h0C, 32'h0, 0, 0);
    for (int n = 0; n < 262; n++) begin
      cyc(0, 5'h00, 0, 1, n[0]);
      rd("R8", 5'h0C);
    end
    chk("R8", "saturated", {24'd0, mCnt}, 32'hFF);

    // R9: preset near the top, and clear.
    cyc(1, 5'h0C, 32'hFFFF_FFFA, 0, 0);
    checkAll("R9");
    for (int n = 0; n < 8; n++) begin cyc(0, 5'h00, 0, 1, 0); rd("R9", 5'h0C); end
    cyc(1, 5'h0C, 32'h0, 0, 0);
    checkAll("R9");

    // R6/R7: checking off.
    cyc(1, 5'h00, 32'h3, 0, 0);
    cyc(1, 5'h08, 32'h0, 0, 0);
    for (int n = 0; n < 5; n++) cyc(0, 5'h00, 0, 1, 1);
    checkAll("R6");
    chk("R7", "genEn while off", {31'd0, genEn}, 32'd1);
    cyc(1, 5'h08, 32'h1, 1, 1);
    checkAll("R6");
    cyc(0, 5'h00, 0, 1, 1);
    checkAll("R6");

    // R10: same-cycle write and event.
    cyc(1, 5'h00, 32'h3, 1, 1);
    checkAll("R10");
    cyc(1, 5'h00, 32'h2, 1, 1);
    checkAll("R10");
    cyc(1, 5'h0C, 32'h40, 1, 0);
    checkAll("R10");
    chk("R10", "count load wins", {24'd0, mCnt}, 32'h40);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule